// File: doc/BRIEF.md
# Split-Mode Event Counter Bank

This block holds a set of physical event counters behind a small register bus. Each physical counter is one wide counter or two independent half-width counters. A size bit per counter in the control register selects the mode. Counters advance on plain per-counter event inputs, and only while the global run bit is set.

Software never writes a live counter directly. A counter write goes into a per-counter holding latch. The latch moves into the live counter when the control register is written with the run bit set, and this works even if the unit is already running. A status register collects wrap events. Reading it returns the pending bits and clears them. Writing it loads the interrupt mask, and the single interrupt line is raised from the pending bits that the mask enables.

Register values are 32 bits wide and travel in the upper half of a 64-bit bus word. Read data appears one cycle after the read strobe.

Top module: `perfcnt_bank`

## Requirements
- R1: After reset all counters, holding latches, the control register, the pending bits and the interrupt mask are zero, `irq_o` is low and `rdata_o` is zero.
- R2: The control register has its run bit at bit 31 and the size bit of physical counter p at bit p. With run set and size bit p clear, `evt_i[p]` adds one to the full 32-bit counter p each cycle, wraps from 0xFFFFFFFF to 0, and `evt_i[p+4]` has no effect. Logical indices p and p+4 both read the full value.
- R3: With size bit p set, logical index p addresses the upper halfword and p+4 the lower halfword of counter p. A read returns the halfword in bits [15:0] of the field with zeros above it. `evt_i[p]` counts the upper half and `evt_i[p+4]` the lower half. Each half wraps at 0xFFFF with no carry into the other half.
- R4: A counter write changes only the holding latch of that counter. The live counter takes the latched value on the next control write that has bit 31 set, including a rewrite while already running. Such a write clears every latch-pending flag.
- R5: In 16-bit mode a write uses bits [15:0] of the field and changes only its own halfword. The other half comes from the pending latch if one exists, otherwise from the live counter.
- R6: While the run bit is clear, no counter changes because of events.
- R7: A wrap of counter p in 32-bit mode, or of its upper half, sets pending bit p. A wrap of the lower half sets pending bit p+4.
- R8: A status read returns the pending bits in field bits [7:0] and clears them. A wrap in the same cycle stays pending.
- R9: A status write loads the mask from field bits [7:0]. `irq_o` is high exactly when some pending bit is also masked on, and a write of zero drops it.
- R10: Field data sits in bus bits [63:32]. Write bits [31:0] are ignored, and reads drive them as zero. Read data appears in the cycle after `rd_en_i` and holds until the next read.
- R11: Address map: 0 to 7 are logical counters, 8 is control, 9 is status. Control reads back its last written value. Other addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 64 | Write data, field in upper 32 bits |
| evt_i | input | 8 | Per-logical-counter event inputs |
| rdata_o | output | 64 | Registered read data, field in upper 32 bits |
| irq_o | output | 1 | Interrupt: pending AND mask, reduced by OR |

## Verification
The bench goes after the staged-write path in several ways. It reads a counter before a commit: a design that writes through would show the new value early. It writes both halves before one commit: a design that merges with the live value instead of the pending latch would lose the first halfword. It recommits while running: a design that commits only on a rising run bit would leave the value stuck in the latch. Lower-half wraps are checked for carries, since a design that chains the halves would bump the upper halfword. A status read that coincides with a wrap is also checked: a design that lets the clear win would drop the new event. Masking is exercised with the pending and mask bits disagreeing, which would expose an interrupt that ignores the mask.

// File: rtl/perfcnt_pkg.sv
`timescale 1ns/1ps
package perfcnt_pkg;
   typedef enum logic [1:0] {
      KIND_CNT  = 2'd0,
      KIND_CTRL = 2'd1,
      KIND_STAT = 2'd2,
      KIND_NONE = 2'd3
   } reg_kind_e;
endpackage

// File: rtl/perfcnt_slice.sv
`timescale 1ns/1ps
module perfcnt_slice #(
   parameter int CNT_W = 32
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             split_i,
   input  logic             run_i,
   input  logic             ev_hi_i,
   input  logic             ev_lo_i,
   input  logic             wr_i,
   input  logic             wr_hi_i,
   input  logic [CNT_W-1:0] wdata_i,
   input  logic             commit_i,
   output logic [CNT_W-1:0] live_o,
   output logic             pend_o,
   output logic             wrap_hi_o,
   output logic             wrap_lo_o
);
   localparam int HALF_W = CNT_W / 2;

   logic [CNT_W-1:0] live_q, hold_q, base, merged, next_cnt;
   logic             pend_q, load;

   assign load = commit_i & pend_q;
   assign base = pend_q ? hold_q : live_q;

   always_comb begin
      if (!split_i)
         merged = wdata_i;
      else if (wr_hi_i)
         merged = {wdata_i[HALF_W-1:0], base[HALF_W-1:0]};
      else
         merged = {base[CNT_W-1:HALF_W], wdata_i[HALF_W-1:0]};
   end

   always_comb begin
      next_cnt  = live_q;
      wrap_hi_o = 1'b0;
      wrap_lo_o = 1'b0;
      if (run_i && !load) begin
         if (split_i) begin
            if (ev_hi_i) begin
               next_cnt[CNT_W-1:HALF_W] = live_q[CNT_W-1:HALF_W] + HALF_W'(1);
               wrap_hi_o = &live_q[CNT_W-1:HALF_W];
            end
            if (ev_lo_i) begin
               next_cnt[HALF_W-1:0] = live_q[HALF_W-1:0] + HALF_W'(1);
               wrap_lo_o = &live_q[HALF_W-1:0];
            end
         end else if (ev_hi_i) begin
            next_cnt  = live_q + CNT_W'(1);
            wrap_hi_o = &live_q;
         end
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         live_q <= '0;
         hold_q <= '0;
         pend_q <= 1'b0;
      end else begin
         live_q <= load ? hold_q : next_cnt;
         if (wr_i) begin
            hold_q <= merged;
            pend_q <= 1'b1;
         end else if (commit_i) begin
            pend_q <= 1'b0;
         end
      end
   end

   assign live_o = live_q;
   assign pend_o = pend_q;
endmodule

// File: rtl/perfcnt_status.sv
`timescale 1ns/1ps
module perfcnt_status #(
   parameter int NUM_LOG = 8
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [NUM_LOG-1:0] set_i,
   input  logic               clr_i,
   input  logic               mask_wr_i,
   input  logic [NUM_LOG-1:0] mask_i,
   output logic [NUM_LOG-1:0] pend_o,
   output logic               irq_o
);
   logic [NUM_LOG-1:0] pend_q, mask_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         pend_q <= '0;
         mask_q <= '0;
      end else begin
         pend_q <= (clr_i ? '0 : pend_q) | set_i;
         if (mask_wr_i) mask_q <= mask_i;
      end
   end

   assign pend_o = pend_q;
   assign irq_o  = |(pend_q & mask_q);
endmodule

// File: rtl/perfcnt_bank.sv
`timescale 1ns/1ps
module perfcnt_bank
   import perfcnt_pkg::*;
#(
   parameter int NUM_PHYS = 4,
   parameter int CNT_W    = 32,
   parameter int BUS_W    = 64,
   parameter int ADDR_W   = 4,
   parameter int EN_BIT   = 31
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  wr_en_i,
   input  logic                  rd_en_i,
   input  logic [ADDR_W-1:0]     addr_i,
   input  logic [BUS_W-1:0]      wdata_i,
   input  logic [2*NUM_PHYS-1:0] evt_i,
   output logic [BUS_W-1:0]      rdata_o,
   output logic                  irq_o
);
   localparam int NUM_LOG   = 2 * NUM_PHYS;
   localparam int HALF_W    = CNT_W / 2;
   localparam int PIDX_W    = $clog2(NUM_PHYS);
   localparam int CTRL_ADDR = NUM_LOG;
   localparam int STAT_ADDR = NUM_LOG + 1;

   if (CNT_W % 2 != 0 || CNT_W < 2) begin : g_chk_even
      $error("CNT_W must be even");
   end
   if (BUS_W <= CNT_W) begin : g_chk_bus
      $error("BUS_W must exceed CNT_W");
   end
   if (NUM_PHYS < 2 || (1 << PIDX_W) != NUM_PHYS) begin : g_chk_pow2
      $error("NUM_PHYS must be a power of two, at least 2");
   end
   if (NUM_LOG > CNT_W || EN_BIT < NUM_PHYS || EN_BIT >= CNT_W) begin : g_chk_fit
      $error("control or status fields do not fit the register width");
   end
   if ((1 << ADDR_W) < NUM_LOG + 2) begin : g_chk_addr
      $error("ADDR_W too small for the register map");
   end

   logic [CNT_W-1:0]        wfield, ctrl_q, rd_field, sel_val;
   logic [BUS_W-1:0]        rdata_q;
   reg_kind_e               kind;
   logic [PIDX_W-1:0]       pidx;
   logic                    sel_hi, run_q, commit;
   logic [CNT_W-1:0]        live_arr [NUM_PHYS];
   logic [NUM_PHYS*CNT_W-1:0] live_flat;
   logic [NUM_PHYS-1:0]     hold_pend, wrap_hi, wrap_lo;
   logic [NUM_LOG-1:0]      wrap_set, stat_pend;
   logic                    unused_low;

   assign wfield     = wdata_i[BUS_W-1 -: CNT_W];
   assign unused_low = ^wdata_i[BUS_W-CNT_W-1:0];
   assign pidx       = addr_i[PIDX_W-1:0];
   assign sel_hi     = addr_i < ADDR_W'(NUM_PHYS);
   assign run_q      = ctrl_q[EN_BIT];

   always_comb begin
      if (addr_i < ADDR_W'(NUM_LOG))        kind = KIND_CNT;
      else if (addr_i == ADDR_W'(CTRL_ADDR)) kind = KIND_CTRL;
      else if (addr_i == ADDR_W'(STAT_ADDR)) kind = KIND_STAT;
      else                                   kind = KIND_NONE;
   end

   assign commit = wr_en_i && (kind == KIND_CTRL) && wfield[EN_BIT];

   for (genvar p = 0; p < NUM_PHYS; p++) begin : g_slice
      perfcnt_slice #(.CNT_W(CNT_W)) u_slice (
         .clk_i     (clk_i),
         .rst_ni    (rst_ni),
         .split_i   (ctrl_q[p]),
         .run_i     (run_q),
         .ev_hi_i   (evt_i[p]),
         .ev_lo_i   (evt_i[p+NUM_PHYS]),
         .wr_i      (wr_en_i && (kind == KIND_CNT) && (pidx == PIDX_W'(p))),
         .wr_hi_i   (sel_hi),
         .wdata_i   (wfield),
         .commit_i  (commit),
         .live_o    (live_arr[p]),
         .pend_o    (hold_pend[p]),
         .wrap_hi_o (wrap_hi[p]),
         .wrap_lo_o (wrap_lo[p])
      );
      assign live_flat[p*CNT_W +: CNT_W] = live_arr[p];
      assign wrap_set[p]                 = wrap_hi[p];
      assign wrap_set[p+NUM_PHYS]        = wrap_lo[p];
   end

   perfcnt_status #(.NUM_LOG(NUM_LOG)) u_status (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .set_i     (wrap_set),
      .clr_i     (rd_en_i && (kind == KIND_STAT)),
      .mask_wr_i (wr_en_i && (kind == KIND_STAT)),
      .mask_i    (wfield[NUM_LOG-1:0]),
      .pend_o    (stat_pend),
      .irq_o     (irq_o)
   );

   assign sel_val = live_arr[pidx];

   always_comb begin
      case (kind)
         KIND_CNT: begin
            if (!ctrl_q[pidx])  rd_field = sel_val;
            else if (sel_hi)    rd_field = CNT_W'(sel_val[CNT_W-1:HALF_W]);
            else                rd_field = CNT_W'(sel_val[HALF_W-1:0]);
         end
         KIND_CTRL: rd_field = ctrl_q;
         KIND_STAT: rd_field = CNT_W'(stat_pend);
         default:   rd_field = '0;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         ctrl_q  <= '0;
         rdata_q <= '0;
      end else begin
         if (wr_en_i && (kind == KIND_CTRL)) ctrl_q <= wfield;
         if (rd_en_i) rdata_q <= BUS_W'(rd_field) << (BUS_W - CNT_W);
      end
   end

   assign rdata_o = rdata_q;
endmodule

// File: rtl/perfcnt_bank_chk.sv
`timescale 1ns/1ps
module perfcnt_bank_chk #(
   parameter int NUM_PHYS = 4,
   parameter int CNT_W    = 32,
   parameter int BUS_W    = 64,
   parameter int ADDR_W   = 4
) (
   input logic                      clk_i,
   input logic                      rst_ni,
   input logic                      wr_en_i,
   input logic                      rd_en_i,
   input logic [ADDR_W-1:0]         addr_i,
   input logic [BUS_W-1:0]          wdata_i,
   input logic [BUS_W-1:0]          rdata_o,
   input logic                      irq_o,
   input logic                      run_q,
   input logic                      commit,
   input logic [NUM_PHYS*CNT_W-1:0] live_flat,
   input logic [NUM_PHYS-1:0]       hold_pend,
   input logic [2*NUM_PHYS-1:0]     stat_pend
);
   localparam int NUM_LOG = 2 * NUM_PHYS;
   localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(NUM_LOG + 1);

   assert_idle_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!run_q && !commit) |=> $stable(live_flat));

   assert_commit_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      commit |=> (hold_pend == '0));

   assert_write_stage_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && addr_i < ADDR_W'(NUM_LOG)) |=> (hold_pend != '0));

   assert_mask_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && addr_i == STAT_A && wdata_i[BUS_W-1 -: CNT_W] == '0) |=> !irq_o);

   assert_rd_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rd_en_i |=> $stable(rdata_o));

   assert_stat_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_en_i && addr_i == STAT_A && !run_q) |=> (stat_pend == '0));
endmodule

bind perfcnt_bank perfcnt_bank_chk #(
   .NUM_PHYS (NUM_PHYS),
   .CNT_W    (CNT_W),
   .BUS_W    (BUS_W),
   .ADDR_W   (ADDR_W)
) u_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .wr_en_i   (wr_en_i),
   .rd_en_i   (rd_en_i),
   .addr_i    (addr_i),
   .wdata_i   (wdata_i),
   .rdata_o   (rdata_o),
   .irq_o     (irq_o),
   .run_q     (run_q),
   .commit    (commit),
   .live_flat (live_flat),
   .hold_pend (hold_pend),
   .stat_pend (stat_pend)
);

// File: tb/perfcnt_bank_bench.sv
`timescale 1ns/1ps
module perfcnt_bank_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr = 1'b0, rd = 1'b0;
   logic [3:0]  addr = '0;
   logic [63:0] wdata = '0;
   logic [7:0]  evt = '0;
   logic [63:0] rdata;
   logic        irq;
   int          checks = 0, errors = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   perfcnt_bank u_perfcnt_bank (
      .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr), .rd_en_i(rd), .addr_i(addr),
      .wdata_i(wdata), .evt_i(evt), .rdata_o(rdata), .irq_o(irq)
   );

   // behavioural reference model
   logic [31:0] m_live [4];
   logic [31:0] m_lat  [4];
   logic [3:0]  m_lp;
   logic [31:0] m_ctrl, m_rd, f, v, base;
   logic [7:0]  m_pend, m_mask, newp;
   logic [15:0] hi, lo;
   logic        cmt;
   int          pi;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 4; i++) begin m_live[i] = 0; m_lat[i] = 0; end
         m_lp = 0; m_ctrl = 0; m_rd = 0; m_pend = 0; m_mask = 0;
      end else begin
         f = wdata[63:32];
         if (rd) begin
            if (addr < 8) begin
               pi = int'(addr) % 4; v = m_live[pi];
               if (m_ctrl[pi]) v = (addr < 4) ? (v >> 16) : (v & 32'hFFFF);
               m_rd = v;
            end else if (addr == 8) m_rd = m_ctrl;
            else if (addr == 9)     m_rd = {24'd0, m_pend};
            else                    m_rd = 0;
         end
         if (wr && addr < 8) begin
            pi = int'(addr) % 4;
            base = m_lp[pi] ? m_lat[pi] : m_live[pi];
            if (!m_ctrl[pi])   m_lat[pi] = f;
            else if (addr < 4) m_lat[pi] = {f[15:0], base[15:0]};
            else               m_lat[pi] = {base[31:16], f[15:0]};
         end
         cmt = wr && addr == 8 && f[31];
         newp = 0;
         for (int p = 0; p < 4; p++) begin
            if (cmt && m_lp[p]) m_live[p] = m_lat[p];
            else if (m_ctrl[31]) begin
               if (m_ctrl[p]) begin
                  hi = m_live[p][31:16]; lo = m_live[p][15:0];
                  if (evt[p])   begin if (hi == 16'hFFFF) newp[p] = 1; hi = hi + 1; end
                  if (evt[p+4]) begin if (lo == 16'hFFFF) newp[p+4] = 1; lo = lo + 1; end
                  m_live[p] = {hi, lo};
               end else if (evt[p]) begin
                  if (m_live[p] == 32'hFFFF_FFFF) newp[p] = 1;
                  m_live[p] = m_live[p] + 1;
               end
            end
         end
         if (wr && addr < 8) m_lp[int'(addr) % 4] = 1'b1;
         if (cmt) m_lp = 0;
         if (wr && addr == 8) m_ctrl = f;
         if (wr && addr == 9) m_mask = f[7:0];
         if (rd && addr == 9) m_pend = newp; else m_pend = m_pend | newp;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks++;
         if (rdata !== {m_rd, 32'd0}) begin
            errors++;
            $display("FAIL R10 per-cycle rdata actual %h expected %h", rdata, {m_rd, 32'd0});
         end
         checks++;
         if (irq !== |(m_pend & m_mask)) begin
            errors++;
            $display("FAIL R9 per-cycle irq actual %b expected %b", irq, |(m_pend & m_mask));
         end
      end
   end

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [3:0] a, input logic [31:0] d, input logic [31:0] junk = 0);
      @(negedge clk); wr = 1; addr = a; wdata = {d, junk};
      @(negedge clk); wr = 0; wdata = 0;
   endtask

   task automatic bus_rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk); rd = 1; addr = a;
      @(negedge clk); rd = 0;
      check(tag, rdata, {exp, 32'd0});
   endtask

   task automatic pulse(input logic [7:0] m, input int n);
      @(negedge clk); evt = m;
      repeat (n) @(negedge clk);
      evt = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 irq after reset", {63'd0, irq}, 64'd0);
      check("R1 rdata after reset", rdata, 64'd0);
      rst_n = 1'b1;
      bus_rd(8, 0, "R1 R11 control reset");
      bus_rd(9, 0, "R1 status reset");
      bus_rd(0, 0, "R1 counter reset");
      bus_wr(0, 100);
      bus_rd(0, 0, "R4 staged write not live");
      bus_wr(8, 32'h8000_0000);
      bus_rd(0, 100, "R4 commit on enable");
      pulse(8'h11, 5);
      bus_rd(0, 105, "R2 32-bit count");
      bus_rd(4, 105, "R2 alias index reads full value");
      bus_wr(8, 0);
      pulse(8'h01, 3);
      bus_rd(0, 105, "R6 no count while disabled");
      bus_wr(8, 32'h1);
      bus_rd(0, 0, "R3 upper half read");
      bus_rd(4, 105, "R3 lower half read");
      bus_wr(0, 32'h1234_ABCD);
      bus_wr(4, 32'h0000_0011);
      bus_rd(0, 0, "R4 halves staged");
      bus_wr(8, 32'h8000_0001);
      bus_rd(0, 32'hABCD, "R5 upper half merged");
      bus_rd(4, 32'h0011, "R5 lower half merged");
      bus_wr(4, 32'hFFFE);
      bus_wr(8, 32'h8000_0001);
      bus_rd(4, 32'hFFFE, "R4 recommit while running");
      pulse(8'h10, 3);
      bus_rd(4, 1, "R3 lower half wraps");
      bus_rd(0, 32'hABCD, "R3 no carry into upper");
      check("R9 masked off", {63'd0, irq}, 64'd0);
      bus_wr(9, 32'h10);
      check("R9 irq raised", {63'd0, irq}, 64'd1);
      bus_rd(9, 32'h10, "R7 R8 lower wrap pending");
      check("R8 irq after clear", {63'd0, irq}, 64'd0);
      bus_rd(9, 0, "R8 status cleared");
      bus_wr(1, 32'hFFFF_FFFF);
      bus_wr(8, 32'h8000_0001);
      pulse(8'h02, 2);
      bus_rd(1, 1, "R2 32-bit wrap");
      check("R9 other bit masked", {63'd0, irq}, 64'd0);
      bus_wr(9, 32'h02);
      check("R9 irq on bit1", {63'd0, irq}, 64'd1);
      bus_wr(9, 0);
      check("R9 zero mask", {63'd0, irq}, 64'd0);
      bus_rd(9, 32'h02, "R7 full wrap bit");
      bus_wr(8, 32'h8000_0001, 32'hFFFF_FFFF);
      bus_rd(8, 32'h8000_0001, "R10 R11 control readback");
      repeat (3) @(negedge clk);
      check("R10 read data holds", rdata, {32'h8000_0001, 32'd0});
      bus_wr(2, 50, 32'hDEAD_BEEF);
      bus_rd(2, 0, "R4 write while running stays staged");
      bus_wr(8, 32'h8000_0001);
      bus_rd(2, 50, "R10 low bits ignored on write");
      bus_rd(12, 0, "R11 unmapped address");
      bus_wr(3, 32'hFFFF_FFFF);
      bus_wr(8, 32'h8000_0001);
      @(negedge clk); evt = 8'h08; rd = 1; addr = 9;
      @(negedge clk); evt = 0; rd = 0;
      check("R8 read during wrap", rdata, 64'd0);
      bus_rd(9, 32'h08, "R8 coincident wrap kept");
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #800000;
      if (!done) begin
         done = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule